// File: doc/BRIEF.md
# UART Receive FIFO with Per-Character Error Tags

This block sits between a UART receive shift register and the status and data registers that a processor reads. Each time the receiver finishes assembling a character, it presents the data byte, the received parity bit and the sampled stop bit for one cycle. The block computes the parity and framing verdicts for that character. It stores the character and its verdicts together as one entry of a small FIFO. The oldest entry is always shown as the readable receive byte.

The error status bits do not follow the input side. They are sticky latches that pick up an entry's tags only when that entry becomes the readable head, so software sees each error next to the byte that caused it. A character that arrives while the FIFO is full is lost. The entry stored last is then tagged with an overrun mark, and intake freezes. It stays frozen until the tagged entry has reached the head, raised the overrun latch, and software has cleared the latches. The block also drives a level receive interrupt. A start-bit pulse from the receiver can optionally raise that interrupt as well.

Top module: `uart_rx_err_fifo`

## Requirements
- R1: After reset, `status` reads 0x00 when `rie` is 0, `rd_data` reads 0x00 and `irq` is 0.
- R2: Stored characters are read out in arrival order. `rd_data` shows the oldest entry, and each `rd_stb` while data is present advances to the next entry on the following edge.
- R3: `status[7]` (data present) goes to 1 on the edge after a character enters an empty FIFO. It stays 1 across reads while entries remain, and returns to 0 only on the edge where a read removes the last entry.
- R4: The parity verdict is an error only when `par_en` is 1 and the parity across the 8 data bits and `rx_par_bit` is wrong: even parity when `par_odd` is 0, odd parity when it is 1. A character with a parity error is still stored. `status[5]` is set only when that entry becomes the head.
- R5: A character whose `rx_stop_bit` is 0 carries a framing error. It is still stored, and `status[4]` is set when that entry becomes the head.
- R6: The latches `status[6]`, `status[5]` and `status[4]` stay set until an `err_clr` pulse clears all three on the next edge. If a latch is set and cleared in the same cycle, it ends up set.
- R7: A character offered while the FIFO holds DEPTH entries, with no read in that cycle, is dropped, and the most recently stored entry gets an overrun tag. `status[6]` rises only when that tagged entry becomes the head.
- R8: After an overrun, every offered character is discarded. Intake resumes only after `err_clr` is pulsed while `status[6]` is 1. A clear pulsed before the tagged entry reaches the head does not resume intake.
- R9: A read and a new character in the same cycle on a full FIFO count as room freed. The character is stored and no overrun occurs.
- R10: `rd_stb` on an empty FIFO has no effect. Data and status are unchanged, and the next character becomes the head normally.
- R11: `status[3]` mirrors `rie`, and bits 2..0 read 0. `irq` is 1 whenever `rie` and `status[7]` are both 1.
- R12: When `rie` and `start_irq_en` are both 1, a `start_detect` pulse drives `irq` high in the same cycle. With either enable at 0, the pulse does not affect `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| char_valid | input | 1 | One-cycle strobe: a character is assembled |
| char_data | input | 8 | Assembled data byte |
| rx_par_bit | input | 1 | Received parity bit |
| rx_stop_bit | input | 1 | Sampled stop bit (0 means framing error) |
| par_en | input | 1 | Parity checking enabled |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| rd_stb | input | 1 | One-cycle read of the head entry |
| err_clr | input | 1 | One-cycle clear of the three error latches |
| rie | input | 1 | Receive interrupt enable |
| start_irq_en | input | 1 | Allow a start-bit pulse to raise the interrupt |
| start_detect | input | 1 | Start bit seen by the receiver |
| rd_data | output | 8 | Head entry data (0 when empty) |
| status | output | 8 | {present, overrun, parity, framing, rie, 3'b000} |
| irq | output | 1 | Receive interrupt request |

## Verification
The bench aims at the moment each error latch rises. It queues a clean byte ahead of a corrupt one, so a design that latches tags on entry instead of at the head shows the error one read too early. It fills the FIFO and forces an overrun, then offers characters before the clear, after an early clear, and after the tagged byte has drained. A design that tags the wrong entry, that does not freeze intake, or that resumes on a premature clear leaves extra or misplaced bytes for the scoreboard to catch. It also drives a read and a write together on a full FIFO, reads from an empty FIFO, and clears a latch in the same cycle it sets. These expose a false overrun, a count underflow, or a clear that wrongly wins.

// File: rtl/urxf_pkg.sv
package urxf_pkg;
    localparam int unsigned RXF_DATA_W = 8;

    typedef struct packed {
        logic [RXF_DATA_W-1:0] data;
        logic                  ovr;
        logic                  pe;
        logic                  fe;
    } rxf_entry_t;
endpackage

// File: rtl/urxf_tagger.sv
module urxf_tagger
    import urxf_pkg::*;
(
    input  logic [RXF_DATA_W-1:0] data_i,
    input  logic                  par_bit_i,
    input  logic                  stop_bit_i,
    input  logic                  par_en_i,
    input  logic                  par_odd_i,
    output rxf_entry_t            entry_o
);
    logic ones_odd;

    always_comb begin
        ones_odd      = (^data_i) ^ par_bit_i;
        entry_o.data  = data_i;
        entry_o.ovr   = 1'b0;
        entry_o.pe    = par_en_i & (ones_odd != par_odd_i);
        entry_o.fe    = ~stop_bit_i;
    end
endmodule

// File: rtl/urxf_queue.sv
module urxf_queue
    import urxf_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push_i,
    input  logic                  pop_i,
    input  rxf_entry_t            wr_entry_i,
    input  logic                  mark_ovr_i,
    output logic [RXF_DATA_W-1:0] head_data_o,
    output logic                  next_ovr_o,
    output logic                  next_pe_o,
    output logic                  next_fe_o,
    output logic [$clog2(DEPTH+1)-1:0] cnt_o
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        rxf_entry_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]       rd;
        logic [PTR_W-1:0]       wr;
        logic [CNT_W-1:0]       cnt;
    } qstate_t;

    qstate_t s_d, s_q;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
        return (p == '0) ? PTR_W'(DEPTH - 1) : p - 1'b1;
    endfunction

    always_comb begin
        s_d = s_q;
        if (mark_ovr_i) begin
            s_d.mem[ptr_dec(s_q.wr)].ovr = 1'b1;
        end
        if (pop_i) begin
            s_d.rd = ptr_inc(s_q.rd);
        end
        if (push_i) begin
            s_d.mem[s_q.wr] = wr_entry_i;
            s_d.wr          = ptr_inc(s_q.wr);
        end
        case ({push_i, pop_i})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        head_data_o = s_q.mem[s_q.rd].data;
        next_ovr_o  = s_q.mem[ptr_inc(s_q.rd)].ovr;
        next_pe_o   = s_q.mem[ptr_inc(s_q.rd)].pe;
        next_fe_o   = s_q.mem[ptr_inc(s_q.rd)].fe;
        cnt_o       = s_q.cnt;
    end
endmodule

// File: rtl/urxf_status.sv
module urxf_status (
    input  logic clk,
    input  logic rst_n,
    input  logic arrive_i,
    input  logic arrive_ovr_i,
    input  logic arrive_pe_i,
    input  logic arrive_fe_i,
    input  logic ovr_on_head_i,
    input  logic ovr_evt_i,
    input  logic err_clr_i,
    input  logic have_data_i,
    input  logic rie_i,
    input  logic start_en_i,
    input  logic start_det_i,
    output logic ovr_o,
    output logic pe_o,
    output logic fe_o,
    output logic blocked_o,
    output logic irq_o
);
    typedef struct packed {
        logic ovr;
        logic pe;
        logic fe;
        logic blocked;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.ovr     = (st_q.ovr & ~err_clr_i) | (arrive_i & arrive_ovr_i) | ovr_on_head_i;
        st_d.pe      = (st_q.pe  & ~err_clr_i) | (arrive_i & arrive_pe_i);
        st_d.fe      = (st_q.fe  & ~err_clr_i) | (arrive_i & arrive_fe_i);
        st_d.blocked = ovr_evt_i | (st_q.blocked & ~(err_clr_i & st_q.ovr));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        ovr_o     = st_q.ovr;
        pe_o      = st_q.pe;
        fe_o      = st_q.fe;
        blocked_o = st_q.blocked;
        irq_o     = rie_i & (have_data_i | (start_en_i & start_det_i));
    end
endmodule

// File: rtl/uart_rx_err_fifo.sv
module uart_rx_err_fifo
    import urxf_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       char_valid,
    input  logic [7:0] char_data,
    input  logic       rx_par_bit,
    input  logic       rx_stop_bit,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       rd_stb,
    input  logic       err_clr,
    input  logic       rie,
    input  logic       start_irq_en,
    input  logic       start_detect,
    output logic [7:0] rd_data,
    output logic [7:0] status,
    output logic       irq
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    rxf_entry_t             in_e;
    logic [RXF_DATA_W-1:0]  head_data;
    logic                   nxt_ovr, nxt_pe, nxt_fe;
    logic [CNT_W-1:0]       q_cnt;
    logic                   empty_w, full_w, pop_w, push_w, ovr_evt_w, ovr_head_w;
    logic                   arrive_w, arr_ovr, arr_pe, arr_fe;
    logic                   ovr_l, pe_l, fe_l, blocked_w, irq_w;

    urxf_tagger u_tagger (
        .data_i     (char_data),
        .par_bit_i  (rx_par_bit),
        .stop_bit_i (rx_stop_bit),
        .par_en_i   (par_en),
        .par_odd_i  (par_odd),
        .entry_o    (in_e)
    );

    always_comb begin
        empty_w    = (q_cnt == '0);
        full_w     = (q_cnt == CNT_W'(DEPTH));
        pop_w      = rd_stb & ~empty_w;
        push_w     = char_valid & ~blocked_w & (~full_w | pop_w);
        ovr_evt_w  = char_valid & ~blocked_w & full_w & ~pop_w;
        ovr_head_w = ovr_evt_w & (q_cnt == CNT_W'(1));
        arrive_w   = 1'b0;
        arr_ovr    = 1'b0;
        arr_pe     = 1'b0;
        arr_fe     = 1'b0;
        if (pop_w && (q_cnt > CNT_W'(1))) begin
            arrive_w = 1'b1;
            arr_ovr  = nxt_ovr;
            arr_pe   = nxt_pe;
            arr_fe   = nxt_fe;
        end else if (push_w && (empty_w || (pop_w && (q_cnt == CNT_W'(1))))) begin
            arrive_w = 1'b1;
            arr_ovr  = in_e.ovr;
            arr_pe   = in_e.pe;
            arr_fe   = in_e.fe;
        end
    end

    urxf_queue #(.DEPTH(DEPTH)) u_queue (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push_w),
        .pop_i       (pop_w),
        .wr_entry_i  (in_e),
        .mark_ovr_i  (ovr_evt_w),
        .head_data_o (head_data),
        .next_ovr_o  (nxt_ovr),
        .next_pe_o   (nxt_pe),
        .next_fe_o   (nxt_fe),
        .cnt_o       (q_cnt)
    );

    urxf_status u_status (
        .clk           (clk),
        .rst_n         (rst_n),
        .arrive_i      (arrive_w),
        .arrive_ovr_i  (arr_ovr),
        .arrive_pe_i   (arr_pe),
        .arrive_fe_i   (arr_fe),
        .ovr_on_head_i (ovr_head_w),
        .ovr_evt_i     (ovr_evt_w),
        .err_clr_i     (err_clr),
        .have_data_i   (~empty_w),
        .rie_i         (rie),
        .start_en_i    (start_irq_en),
        .start_det_i   (start_detect),
        .ovr_o         (ovr_l),
        .pe_o          (pe_l),
        .fe_o          (fe_l),
        .blocked_o     (blocked_w),
        .irq_o         (irq_w)
    );

    always_comb begin
        rd_data = empty_w ? 8'h00 : head_data;
        status  = {~empty_w, ovr_l, pe_l, fe_l, rie, 3'b000};
        irq     = irq_w;
    end
endmodule

// File: rtl/urxf_checker.sv
module urxf_checker #(
    parameter int unsigned DEPTH = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       char_valid,
    input logic                       rd_stb,
    input logic                       err_clr,
    input logic [7:0]                 status,
    input logic                       irq,
    input logic                       blocked,
    input logic [$clog2(DEPTH+1)-1:0] cnt
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    AST_EMPTY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[7] && !char_valid) |=> !status[7]); // R3
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status[6] && !err_clr) |=> status[6]); // R6
    AST_PE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status[5] && !err_clr) |=> status[5]); // R6
    AST_FE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status[4] && !err_clr) |=> status[4]); // R6
    AST_FROZEN_INTAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked && char_valid && !rd_stb) |=> $stable(cnt)); // R8
    AST_NO_OVERFILL: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH)); // R7
    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (status[3] && status[7]) |-> irq); // R11
endmodule

bind uart_rx_err_fifo urxf_checker #(.DEPTH(DEPTH)) u_urxf_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .char_valid (char_valid),
    .rd_stb     (rd_stb),
    .err_clr    (err_clr),
    .status     (status),
    .irq        (irq),
    .blocked    (blocked_w),
    .cnt        (q_cnt)
);

// File: tb/uart_rx_err_fifo_bench.sv
module uart_rx_err_fifo_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       char_valid = 1'b0;
    logic [7:0] char_data = 8'h00;
    logic       rx_par_bit = 1'b0;
    logic       rx_stop_bit = 1'b1;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       rd_stb = 1'b0;
    logic       err_clr = 1'b0;
    logic       rie = 1'b0;
    logic       start_irq_en = 1'b0;
    logic       start_detect = 1'b0;
    logic [7:0] rd_data;
    logic [7:0] status;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        logic [7:0] d;
        logic       ovr;
        logic       pe;
        logic       fe;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_rx_err_fifo u_uart_rx_err_fifo (
        .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_data(char_data),
        .rx_par_bit(rx_par_bit), .rx_stop_bit(rx_stop_bit), .par_en(par_en),
        .par_odd(par_odd), .rd_stb(rd_stb), .err_clr(err_clr), .rie(rie),
        .start_irq_en(start_irq_en), .start_detect(start_detect),
        .rd_data(rd_data), .status(status), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // driver: offers one character; pushes the expected entry when it should be kept
    task automatic send(input logic [7:0] d, input logic pbit, input logic stop, input bit keep);
        exp_t e;
        char_valid  = 1'b1;
        char_data   = d;
        rx_par_bit  = pbit;
        rx_stop_bit = stop;
        @(negedge clk);
        char_valid  = 1'b0;
        rx_stop_bit = 1'b1;
        if (keep) begin
            e.d   = d;
            e.ovr = 1'b0;
            e.pe  = par_en && (((^d) ^ pbit) != par_odd);
            e.fe  = !stop;
            exp_q.push_back(e);
        end
    endtask

    // monitor: pops the expected head and compares what the design shows, then reads
    task automatic monitor_read(input string req);
        exp_t e;
        if (exp_q.size() == 0) begin
            chk({req, " scoreboard empty"}, 8'h01, 8'h00);
            return;
        end
        e = exp_q.pop_front();
        chk({req, " head data"}, rd_data, e.d);
        chk({req, " present"}, {7'd0, status[7]}, 8'h01);
        if (e.ovr) chk({req, " R7 ovr latch at head"}, {7'd0, status[6]}, 8'h01);
        if (e.pe)  chk({req, " R4 pe latch at head"}, {7'd0, status[5]}, 8'h01);
        if (e.fe)  chk({req, " R5 fe latch at head"}, {7'd0, status[4]}, 8'h01);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic clear_errs();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        exp_t e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 status", status, 8'h00);
        chk("R1 rd_data", rd_data, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);

        // R10 read on empty has no effect
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        chk("R10 status after empty read", status, 8'h00);
        chk("R10 rd_data after empty read", rd_data, 8'h00);
        send(8'h33, 1'b0, 1'b1, 1'b1);
        chk("R10 next char becomes head", rd_data, 8'h33);
        monitor_read("R10");
        chk("R10 empty after one read", status, 8'h00);

        // R2 / R3 ordering and the present bit
        send(8'hA1, 1'b0, 1'b1, 1'b1);
        chk("R3 present after first char", status, 8'h80);
        send(8'hB2, 1'b0, 1'b1, 1'b1);
        send(8'hC3, 1'b0, 1'b1, 1'b1);
        monitor_read("R2");
        chk("R3 present with two left", {7'd0, status[7]}, 8'h01);
        monitor_read("R2");
        chk("R3 present with one left", {7'd0, status[7]}, 8'h01);
        monitor_read("R2");
        chk("R3 cleared when emptied", status, 8'h00);

        // R4 parity, even mode, tag held back until head
        par_en = 1'b1; par_odd = 1'b0;
        send(8'h00, 1'b0, 1'b1, 1'b1);
        send(8'h03, 1'b1, 1'b1, 1'b1);
        chk("R4 pe not yet visible", {7'd0, status[5]}, 8'h00);
        monitor_read("R4");
        chk("R4 pe visible at head", {7'd0, status[5]}, 8'h01);
        monitor_read("R4");
        chk("R6 pe sticky after drain", status, 8'h20);
        clear_errs();
        chk("R6 clear drops pe", status, 8'h00);
        // odd mode
        par_odd = 1'b1;
        send(8'h01, 1'b0, 1'b1, 1'b1);
        chk("R4 odd good parity", status, 8'h80);
        monitor_read("R4");
        send(8'h01, 1'b1, 1'b1, 1'b1);
        chk("R4 odd bad parity", status, 8'hA0);
        monitor_read("R4");
        clear_errs();
        par_en = 1'b0;
        send(8'h01, 1'b1, 1'b1, 1'b1);
        chk("R4 parity disabled", status, 8'h80);
        monitor_read("R4");
        par_odd = 1'b0;

        // R5 framing
        send(8'h5A, 1'b0, 1'b0, 1'b1);
        chk("R5 fe at head", status, 8'h90);
        monitor_read("R5");
        chk("R5 fe sticky when empty", status, 8'h10);
        clear_errs();
        chk("R6 clear drops fe", status, 8'h00);

        // R6 set wins over clear in the same cycle
        err_clr = 1'b1;
        send(8'h6B, 1'b0, 1'b0, 1'b1);
        err_clr = 1'b0;
        chk("R6 set beats clear", status, 8'h90);
        monitor_read("R6");
        clear_errs();
        chk("R6 cleared", status, 8'h00);

        // R7 / R8 overrun and frozen intake
        send(8'h10, 1'b0, 1'b1, 1'b1);
        send(8'h11, 1'b0, 1'b1, 1'b1);
        send(8'h12, 1'b0, 1'b1, 1'b1);
        send(8'h13, 1'b0, 1'b1, 1'b1);
        send(8'h14, 1'b0, 1'b1, 1'b0);
        e = exp_q[exp_q.size()-1];
        e.ovr = 1'b1;
        exp_q[exp_q.size()-1] = e;
        chk("R7 ovr hidden until head", {7'd0, status[6]}, 8'h00);
        send(8'h15, 1'b0, 1'b1, 1'b0);
        clear_errs();
        send(8'h16, 1'b0, 1'b1, 1'b0);
        monitor_read("R8");
        monitor_read("R8");
        monitor_read("R8");
        chk("R7 ovr latch when tagged head", status, 8'hC0);
        send(8'h17, 1'b0, 1'b1, 1'b0);
        monitor_read("R7");
        chk("R8 dropped chars absent", status, 8'h40);
        send(8'h19, 1'b0, 1'b1, 1'b0);
        chk("R8 still frozen before clear", status, 8'h40);
        clear_errs();
        chk("R8 clear drops ovr", status, 8'h00);
        send(8'h18, 1'b0, 1'b1, 1'b1);
        chk("R8 intake resumed", rd_data, 8'h18);
        monitor_read("R8");

        // R9 read and write together on a full FIFO
        send(8'h20, 1'b0, 1'b1, 1'b1);
        send(8'h21, 1'b0, 1'b1, 1'b1);
        send(8'h22, 1'b0, 1'b1, 1'b1);
        send(8'h23, 1'b0, 1'b1, 1'b1);
        e = exp_q.pop_front();
        chk("R9 head before swap", rd_data, e.d);
        rd_stb = 1'b1;
        send(8'h24, 1'b0, 1'b1, 1'b1);
        rd_stb = 1'b0;
        chk("R9 no overrun", status, 8'h80);
        monitor_read("R9");
        monitor_read("R9");
        monitor_read("R9");
        monitor_read("R9");
        chk("R9 drained", status, 8'h00);

        // R11 interrupt level
        rie = 1'b1;
        #1;
        chk("R11 enable mirrored", status, 8'h08);
        chk("R11 irq idle", {7'd0, irq}, 8'h00);
        @(negedge clk);
        send(8'h44, 1'b0, 1'b1, 1'b1);
        chk("R11 irq with data", {7'd0, irq}, 8'h01);
        monitor_read("R11");
        chk("R11 irq after drain", {7'd0, irq}, 8'h00);

        // R12 start-bit interrupt
        start_irq_en = 1'b1;
        start_detect = 1'b1;
        #1;
        chk("R12 start raises irq", {7'd0, irq}, 8'h01);
        start_detect = 1'b0;
        #1;
        chk("R12 irq drops after pulse", {7'd0, irq}, 8'h00);
        rie = 1'b0;
        start_detect = 1'b1;
        #1;
        chk("R12 gated by rie", {7'd0, irq}, 8'h00);
        start_detect = 1'b0;
        start_irq_en = 1'b0;
        @(negedge clk);

        if (exp_q.size() != 0) chk("R2 scoreboard leftover", 8'(exp_q.size()), 8'h00);
        summary();
        $finish;
    end
endmodule